// File: doc/BRIEF.md
# Display Identity Bit Streamer

This block sends the contents of a 128-byte identity store as an endless serial stream on an open-drain data line. A slow, free-running clock from the display side (`vclk_in`) paces the stream. The block samples that clock into the system clock domain and advances the stream by one bit on each rising edge. After reset it first counts a run of edges as a synchronisation phase and keeps the line released throughout it. It then sends the bytes in ascending address order, most significant bit first. Each byte is followed by one released filler bit, and the address wraps from the top of the store back to zero.

The store is external and is read through a synchronous byte port. A read is requested as a one-cycle pulse on `rd_en` with the address on `rd_addr`, and the data must appear on `rd_data` on the following clock. The block issues the read for the next byte while the filler bit is on the line, so the byte is in place before its first bit is due. A mode controller can restart the stream from address zero with a one-cycle `restart` pulse. It can also pause the stream with `out_en`. Every phase of `vclk_in` is assumed to last at least four system clocks.

Top module: `vsync_bit_streamer`

## Requirements
- R1: During and right after reset, `sda_low` is 0 (line released) and no read is issued.
- R2: The first nine rising edges of `vclk_in` after reset leave `sda_low` at 0. The ninth edge issues a read of address 0.
- R3: The tenth rising edge presents bit 7 of the byte at address 0.
- R4: Each later rising edge presents the next bit, from bit 7 down to bit 0. A bit of value 0 is shown as `sda_low` = 1.
- R5: After bit 0 of every byte, the next rising edge gives a ninth filler slot in which `sda_low` is 0.
- R6: Bytes follow in ascending address order. After address 127 the stream continues with address 0 and no extra slot is inserted.
- R7: A `restart` pulse issues a read of address 0 on the next clock. It releases the line, and the next rising edge presents bit 7 of address 0, with no new synchronisation phase.
- R8: While `out_en` is 0, `sda_low` is 0 and rising edges are ignored. When `out_en` returns to 1, the bit that was showing is shown again, and the stream resumes from it.
- R9: The read of the next byte is issued on the edge that starts the filler slot. It is a single-cycle `rd_en` pulse with the address one above the previous one, modulo 128.
- R10: A bit of value 1 is never driven: `sda_low` is 0 for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vclk_in | input | 1 | Asynchronous stream pacing clock |
| restart | input | 1 | One-cycle request to restart the stream at address 0 |
| out_en | input | 1 | 1 lets the stream run and drive; 0 pauses and releases |
| rd_en | output | 1 | Store read strobe |
| rd_addr | output | ADDR_W | Store read address |
| rd_data | input | DATA_W | Store data, valid one clock after `rd_en` |
| sda_low | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
Two cases are hard to reach from the ports. The first is the wrap at the top of the store, which needs more than a thousand pacing edges after synchronisation. The second is a pause that falls in the middle of a byte. The bench keeps an arithmetic model of slot and address and walks the stream through the whole store and past the wrap, checking every slot. It then drops `out_en` partway through a byte, sends edges that must be ignored, and re-enables to confirm the stream resumes from the same bit. A restart partway through a byte is exercised last.

// File: rtl/vsync_bit_streamer.sv
module vsync_bit_streamer #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_EDGES  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vclk_in,
  input  logic              restart,
  input  logic              out_en,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sda_low
);
  localparam int SLOT_W    = $clog2(DATA_W + 1);
  localparam int CNT_W     = $clog2(SYNC_EDGES + 1);
  localparam int NULL_SLOT = DATA_W;

  logic [2:0]        vs;
  logic [CNT_W-1:0]  sync_cnt;
  logic              live;
  logic [SLOT_W-1:0] slot;
  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] byte_q;
  logic              rd_pend;

  wire rise    = vs[1] & ~vs[2];
  wire step    = rise & out_en;
  wire in_null = (slot == SLOT_W'(NULL_SLOT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs       <= '1;
      sync_cnt <= '0;
      live     <= 1'b0;
      slot     <= SLOT_W'(NULL_SLOT);
      sh       <= '0;
      byte_q   <= '0;
      rd_en    <= 1'b0;
      rd_addr  <= '0;
      rd_pend  <= 1'b0;
    end else begin
      vs      <= {vs[1:0], vclk_in};
      rd_en   <= 1'b0;
      rd_pend <= rd_en;
      if (rd_pend) byte_q <= rd_data;
      if (restart) begin
        live    <= 1'b1;
        slot    <= SLOT_W'(NULL_SLOT);
        rd_en   <= 1'b1;
        rd_addr <= '0;
      end else if (step) begin
        if (!live) begin
          sync_cnt <= sync_cnt + 1'b1;
          if (sync_cnt == CNT_W'(SYNC_EDGES - 1)) begin
            live    <= 1'b1;
            slot    <= SLOT_W'(NULL_SLOT);
            rd_en   <= 1'b1;
            rd_addr <= '0;
          end
        end else if (in_null) begin
          slot <= '0;
          sh   <= byte_q;
        end else begin
          slot <= slot + 1'b1;
          sh   <= sh << 1;
          if (slot == SLOT_W'(DATA_W - 1)) begin
            rd_en   <= 1'b1;
            rd_addr <= rd_addr + 1'b1;
          end
        end
      end
    end
  end

  assign sda_low = out_en & live & ~in_null & ~sh[DATA_W-1];
endmodule

// File: rtl/vsync_bit_streamer_chk.sv
module vsync_bit_streamer_chk #(
  parameter int ADDR_W    = 7,
  parameter int SLOT_W    = 4,
  parameter int NULL_SLOT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              restart,
  input logic              out_en,
  input logic              live,
  input logic [SLOT_W-1:0] slot,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              sda_low
);
  AST_SILENT_SYNC: assert property (@(posedge clk) disable iff (!rst_n) !live |-> !sda_low); // R2
  AST_NULL_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) (slot == SLOT_W'(NULL_SLOT)) |-> !sda_low); // R5
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n) restart |=> (rd_en && rd_addr == '0)); // R7
  AST_PAUSE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) !out_en |-> !sda_low); // R8
  AST_PAUSE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (!out_en && !restart) |=> ($stable(slot) && $stable(rd_addr))); // R8
  AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && !restart) |=> !rd_en); // R9
endmodule

bind vsync_bit_streamer vsync_bit_streamer_chk #(
  .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .NULL_SLOT(NULL_SLOT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .restart(restart), .out_en(out_en), .live(live),
  .slot(slot), .rd_en(rd_en), .rd_addr(rd_addr), .sda_low(sda_low)
);

// File: tb/vsync_bit_streamer_tb.sv
module vsync_bit_streamer_tb_top;
  logic clk = 0, rst_n = 0, vclk_in = 0, restart = 0, out_en = 1;
  logic rd_en, sda_low;
  logic [6:0] rd_addr;
  logic [7:0] rd_data = 0;
  int total = 0, fails = 0, rd_count = 0;
  logic [6:0] last_rd = 0;
  int exp_slot = 8;
  int exp_addr = 0;
  int shown = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vsync_bit_streamer dut_i (
    .clk(clk), .rst_n(rst_n), .vclk_in(vclk_in), .restart(restart), .out_en(out_en),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .sda_low(sda_low)
  );

  function automatic logic [7:0] pattern(input logic [6:0] a);
    return 8'((int'(a) * 37 + 91) & 255);
  endfunction

  always @(posedge clk) begin
    if (rd_en) begin
      rd_data  <= pattern(rd_addr);
      last_rd  <= rd_addr;
      rd_count <= rd_count + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse();
    vclk_in = 1;
    repeat (8) @(negedge clk);
    vclk_in = 0;
    repeat (8) @(negedge clk);
  endtask

  function automatic int exp_line();
    logic [7:0] b;
    if (exp_slot == 8) return 0;
    b = pattern(7'(exp_addr));
    return b[7 - exp_slot] ? 0 : 1;
  endfunction

  task automatic step_check();
    int rc;
    string tag;
    rc = rd_count;
    pulse();
    if (exp_slot == 8) exp_slot = 0;
    else begin
      exp_slot++;
      if (exp_slot == 8) exp_addr = (exp_addr + 1) % 128;
    end
    if (exp_slot == 8) begin
      check(sda_low == 0, "R5 filler slot released", sda_low, 0);
      check(last_rd == 7'(exp_addr) && rd_count == rc + 1, "R9 next-byte read", last_rd, exp_addr);
      shown++;
    end else begin
      if (shown == 0 && exp_slot == 0) tag = "R3 first bit of address 0";
      else if (shown >= 128 && exp_addr < 3) tag = "R6 stream after wrap";
      else if (exp_line() == 0) tag = "R10 one bit released";
      else tag = "R4 zero bit driven";
      check(sda_low == exp_line(), tag, sda_low, exp_line());
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sda_low == 0 && rd_en == 0, "R1 reset state", sda_low, 0);
    rst_n = 1;
    @(negedge clk);
    check(sda_low == 0 && rd_count == 0, "R1 after reset", rd_count, 0);
    for (int i = 0; i < 9; i++) begin
      pulse();
      check(sda_low == 0, "R2 sync phase released", sda_low, 0);
    end
    check(rd_count == 1 && last_rd == 0, "R2 read of address 0 at ninth edge", last_rd, 0);
    for (int i = 0; i < 131 * 9; i++) step_check();
    for (int i = 0; i < 3; i++) step_check();
    out_en = 0;
    @(negedge clk);
    check(sda_low == 0, "R8 paused line released", sda_low, 0);
    for (int i = 0; i < 5; i++) begin
      pulse();
      check(sda_low == 0, "R8 edges ignored while paused", sda_low, 0);
    end
    out_en = 1;
    repeat (2) @(negedge clk);
    check(sda_low == exp_line(), "R8 held bit shown again", sda_low, exp_line());
    for (int i = 0; i < 12; i++) step_check();
    restart = 1;
    @(negedge clk);
    restart = 0;
    repeat (3) @(negedge clk);
    check(sda_low == 0, "R7 released after restart", sda_low, 0);
    check(last_rd == 0, "R7 restart reads address 0", last_rd, 0);
    exp_slot = 8;
    exp_addr = 0;
    shown = 0;
    for (int i = 0; i < 20; i++) step_check();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule